// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is a single programmable performance-monitoring counter. On every clock it receives a packed vector of small per-cycle counts. The vector is organised as groups of eight sub-events. An 8-bit event code picks one group, and an 8-bit unit mask picks which of that group's eight sub-events are added into the cycle total.

The total then passes through a qualification stage before it reaches a 48-bit accumulator. That stage has a threshold compare that can be inverted, an optional rising-edge detector, and a privilege gate that checks the current privilege level against separate kernel and user enables. The counter sets a sticky flag when it wraps, and the flag can raise an interrupt.

Software reaches the block through a small word-addressed register port. It can configure the counter, read or preset the count, and clear the overflow flag.

Top module: `qec_core`

## Requirements
- R1: The event code selects group g, made of sub-events g*8 to g*8+7; sub-event k occupies bits [k*SUB_W +: SUB_W] of evt_i. A code of NUM_EVT or above selects nothing, so the cycle total is 0.
- R2: Each set bit j of the unit mask adds sub-event j of the selected group into the cycle total, so several bits may be combined.
- R3: With threshold 0, an enabled and privilege-qualified cycle adds the raw cycle total, and the edge and invert bits have no effect.
- R4: With a nonzero threshold, a qualified cycle adds exactly 1 when the total is greater than or equal to the threshold, and adds 0 otherwise.
- R5: With the invert bit set and a nonzero threshold, the compare becomes total strictly less than the threshold.
- R6: In edge mode with a nonzero threshold, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. The remembered condition is cleared at reset and while the counter is disabled.
- R7: A cycle counts only when priv_i is 0 and the kernel enable is set, or when priv_i is 1, 2 or 3 and the user enable is set.
- R8: While the enable bit is clear the count does not change. A configuration write takes effect from the cycle after the write.
- R9: A write to the count register (address 1) loads the count and takes priority over any increment in the same cycle. Reads of address 1 return the count.
- R10: When the count wraps past all ones, the overflow flag (address 2, bit 0) is set and stays set. irq_o equals the flag ANDed with the interrupt enable. Writing 1 to bit 0 of address 2 clears the flag, unless a wrap occurs in the same cycle.
- R11: After reset the configuration, count and flag read back 0, and irq_o is 0.
- R12: The configuration register (address 0) holds the following fields:
  - code [7:0]
  - mask [15:8]
  - user enable [16]
  - kernel enable [17]
  - edge [18]
  - interrupt enable [19]
  - invert [20]
  - enable [21]
  - threshold [29:22]

  It reads back exactly what was written, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT*8*SUB_W | Per-cycle counts of all sub-events |
| priv_i | input | 2 | Current privilege level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 config, 1 count, 2 status) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The main path is driven in several ways. Sparse stimulus puts activity into a single group, which separates correct group selection from adjacent or out-of-range codes. Dense pseudo-random totals are run under each threshold and invert setting, which exercises the at-threshold boundary in both directions. Square-wave and burst patterns in edge mode show whether a long true run counts once and whether disabling the counter forgets the last state. Privilege sweeps and a preset near all ones cover the privilege gate, the wrap, the write priority and the flag clear.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int unsigned LANES = 8;

  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_CNT = 2'd1;
  localparam logic [1:0] ADDR_STS = 2'd2;

  typedef struct packed {
    logic [7:0] thr;
    logic       en;
    logic       inv;
    logic       irq_en;
    logic       edge_md;
    logic       os_en;
    logic       usr_en;
    logic [7:0] umask;
    logic [7:0] code;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/qec_sum.sv
module qec_sum #(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned SUB_W   = 2,
  parameter int unsigned SUM_W   = SUB_W + 3
) (
  input  logic [NUM_EVT*qec_pkg::LANES*SUB_W-1:0] evt_i,
  input  logic [7:0]                              code_i,
  input  logic [7:0]                              umask_i,
  output logic [SUM_W-1:0]                        sum_o
);
  localparam int unsigned LANES = qec_pkg::LANES;

  logic [SUM_W-1:0] grp_sum [NUM_EVT];

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_grp
    always_comb begin
      grp_sum[g] = '0;
      for (int j = 0; j < LANES; j++) begin
        if (umask_i[j])
          grp_sum[g] = grp_sum[g] + SUM_W'(evt_i[(g*LANES+j)*SUB_W +: SUB_W]);
      end
    end
  end

  always_comb begin
    sum_o = '0;
    for (int g = 0; g < NUM_EVT; g++)
      if (code_i == 8'(g)) sum_o = grp_sum[g];
  end
endmodule

// File: rtl/qec_qual.sv
module qec_qual #(
  parameter int unsigned SUM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             priv_ok_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [7:0]       thr_i,
  input  logic             inv_i,
  input  logic             edge_i,
  output logic [SUM_W-1:0] inc_o
);
  localparam int unsigned CMP_W = (SUM_W > 8) ? SUM_W : 8;

  logic ge, cond, qual, prev_q;

  assign ge   = CMP_W'(sum_i) >= CMP_W'(thr_i);
  assign cond = (thr_i != 8'd0) && (inv_i ? !ge : ge);
  assign qual = cond && priv_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_q <= 1'b0;
    else if (!en_i) prev_q <= 1'b0;
    else            prev_q <= qual;
  end

  always_comb begin
    if (!en_i || !priv_ok_i) inc_o = '0;
    else if (thr_i == 8'd0)  inc_o = sum_i;
    else if (edge_i)         inc_o = SUM_W'(qual && !prev_q);
    else                     inc_o = SUM_W'(qual);
  end
endmodule

// File: rtl/qec_ctr.sv
module qec_ctr #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned SUM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [SUM_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W:0] nxt;

  assign nxt    = {1'b0, cnt_o} + (CNT_W+1)'(inc_i);
  assign wrap_o = !wr_i && nxt[CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (wr_i) cnt_o <= wdata_i;
    else           cnt_o <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/qec_core.sv
module qec_core #(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned SUB_W   = 2,
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned DATA_W  = 64
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [NUM_EVT*qec_pkg::LANES*SUB_W-1:0] evt_i,
  input  logic [1:0]                              priv_i,
  input  logic                                    reg_we_i,
  input  logic [1:0]                              reg_addr_i,
  input  logic [DATA_W-1:0]                       reg_wdata_i,
  output logic [DATA_W-1:0]                       reg_rdata_o,
  output logic                                    irq_o
);
  import qec_pkg::*;

  localparam int unsigned SUM_W = SUB_W + $clog2(LANES);

  cfg_t             cfg_q;
  logic             ovf_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum, inc;
  logic             cfg_wr, cnt_wr, sts_clr, wrap, priv_ok;

  assign cfg_wr  = reg_we_i && (reg_addr_i == ADDR_CFG);
  assign cnt_wr  = reg_we_i && (reg_addr_i == ADDR_CNT);
  assign sts_clr = reg_we_i && (reg_addr_i == ADDR_STS) && reg_wdata_i[0];
  assign priv_ok = (priv_i == 2'd0) ? cfg_q.os_en : cfg_q.usr_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_t'(reg_wdata_i[CFG_W-1:0]);
      // a wrap in the clearing cycle wins
      ovf_q <= wrap || (ovf_q && !sts_clr);
    end
  end

  qec_sum #(.NUM_EVT(NUM_EVT), .SUB_W(SUB_W), .SUM_W(SUM_W)) i_sum (
    .evt_i  (evt_i),
    .code_i (cfg_q.code),
    .umask_i(cfg_q.umask),
    .sum_o  (sum)
  );

  qec_qual #(.SUM_W(SUM_W)) i_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cfg_q.en),
    .priv_ok_i(priv_ok),
    .sum_i    (sum),
    .thr_i    (cfg_q.thr),
    .inv_i    (cfg_q.inv),
    .edge_i   (cfg_q.edge_md),
    .inc_o    (inc)
  );

  qec_ctr #(.CNT_W(CNT_W), .SUM_W(SUM_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cnt_wr),
    .wdata_i(reg_wdata_i[CNT_W-1:0]),
    .inc_i  (inc),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CFG: reg_rdata_o = DATA_W'(cfg_q);
      ADDR_CNT: reg_rdata_o = DATA_W'(cnt_q);
      ADDR_STS: reg_rdata_o = DATA_W'(ovf_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = ovf_q && cfg_q.irq_en;
endmodule

// File: rtl/qec_chk.sv
module qec_chk #(
  parameter int unsigned CNT_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             en_i,
  input logic [7:0]       thr_i,
  input logic             ovf_i,
  input logic             ovf_clr_i,
  input logic             irq_i
);
  // R8
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr_i) |=> $stable(cnt_i));

  // R9
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_i == $past(cnt_wdata_i)));

  // R4
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr_i && en_i && thr_i != 8'd0) |=>
      (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1));

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !ovf_clr_i) |=> ovf_i);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ovf_i);
endmodule

bind qec_core qec_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_wr_i   (cnt_wr),
  .cnt_wdata_i(reg_wdata_i[CNT_W-1:0]),
  .cnt_i      (cnt_q),
  .en_i       (cfg_q.en),
  .thr_i      (cfg_q.thr),
  .ovf_i      (ovf_q),
  .ovf_clr_i  (sts_clr),
  .irq_i      (irq_o)
);

// File: tb/test_qec_core.sv
module test_qec_core;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EVT = 4;
  localparam int SUB_W   = 2;
  localparam int CNT_W   = 48;
  localparam int DATA_W  = 64;
  localparam int EVT_W   = NUM_EVT*8*SUB_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [EVT_W-1:0]  evt = '0;
  logic [1:0]        priv = 2'd0;
  logic              we = 1'b0;
  logic [1:0]        addr = 2'd1;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  qec_core #(.NUM_EVT(NUM_EVT), .SUB_W(SUB_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_qec_core (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .priv_i(priv),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  logic [29:0]      m_cfg;
  logic [CNT_W-1:0] m_cnt;
  logic             m_ovf, m_prev;
  int               s, inc;
  logic             pok, ge, cnd, ql, wrp;
  logic [CNT_W:0]   t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_cnt = '0; m_ovf = 1'b0; m_prev = 1'b0;
    end else begin
      s = 0;
      if (int'(m_cfg[7:0]) < NUM_EVT)
        for (int j = 0; j < 8; j++)
          if (m_cfg[8+j]) s += int'(evt[(int'(m_cfg[7:0])*8+j)*SUB_W +: SUB_W]);
      pok = (priv == 2'd0) ? m_cfg[17] : m_cfg[16];
      ge  = s >= int'(m_cfg[29:22]);
      cnd = (m_cfg[29:22] != 0) && (m_cfg[20] ? !ge : ge);
      ql  = cnd && pok;
      if (!m_cfg[21] || !pok)   inc = 0;
      else if (m_cfg[29:22]==0) inc = s;
      else if (m_cfg[18])       inc = (ql && !m_prev) ? 1 : 0;
      else                      inc = ql ? 1 : 0;
      m_prev = m_cfg[21] ? ql : 1'b0;
      wrp = 1'b0;
      if (we && addr == 2'd1) m_cnt = wdata[CNT_W-1:0];
      else begin
        t = {1'b0, m_cnt} + (CNT_W+1)'(inc);
        m_cnt = t[CNT_W-1:0];
        wrp = t[CNT_W];
      end
      m_ovf = wrp || (m_ovf && !(we && addr == 2'd2 && wdata[0]));
      if (we && addr == 2'd0) m_cfg = wdata[29:0];
    end
  end

  function automatic logic [DATA_W-1:0] m_read(logic [1:0] a);
    case (a)
      2'd0:    return DATA_W'(m_cfg);
      2'd1:    return DATA_W'(m_cnt);
      2'd2:    return DATA_W'(m_ovf);
      default: return '0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (rdata !== m_read(addr)) begin
        n_fail++;
        $display("FAIL %s rdata addr %0d actual %h expected %h", cur_req, addr, rdata, m_read(addr));
      end
      n_chk++;
      if (irq !== (m_ovf && m_cfg[19])) begin
        n_fail++;
        $display("FAIL %s irq actual %b expected %b", cur_req, irq, m_ovf && m_cfg[19]);
      end
    end
  end

  function automatic logic [DATA_W-1:0] mk(int code, int um, bit usr, bit os, bit edg,
                                           bit ie, bit inv, bit en, int thr);
    return DATA_W'({thr[7:0], en, inv, ie, edg, os, usr, um[7:0], code[7:0]});
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [DATA_W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0; addr = 2'd1;
  endtask

  task automatic rd(logic [1:0] a);
    addr = a; step(); addr = 2'd1;
  endtask

  task automatic rnd_evt(int n);
    for (int i = 0; i < n; i++) begin
      evt = {$urandom, $urandom};
      step();
    end
  endtask

  task automatic one_grp(int g, int n);
    for (int i = 0; i < n; i++) begin
      evt = '0;
      for (int j = 0; j < 8; j++) evt[(g*8+j)*SUB_W +: SUB_W] = SUB_W'($urandom);
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    cur_req = "R11";
    rd(2'd0); rd(2'd2);
    rst_n = 1'b1;
    step();
    rd(2'd0); rd(2'd1); rd(2'd2);

    cur_req = "R8";
    wr(2'd0, mk(0, 8'hFF, 1, 1, 0, 0, 0, 0, 0));
    rnd_evt(6);
    wr(2'd0, mk(0, 8'hFF, 1, 1, 0, 0, 0, 1, 0));
    rnd_evt(6);

    cur_req = "R12";
    wr(2'd0, mk(8'hA5, 8'h3C, 1, 0, 1, 0, 1, 0, 8'h9E));
    rd(2'd0);
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0);

    cur_req = "R1";
    for (int g = 0; g < NUM_EVT; g++) begin
      wr(2'd0, mk(g, 8'hFF, 1, 1, 0, 0, 0, 1, 0));
      for (int h = 0; h < NUM_EVT; h++) one_grp(h, 3);
    end
    wr(2'd0, mk(NUM_EVT, 8'hFF, 1, 1, 0, 0, 0, 1, 0));
    rnd_evt(5);
    wr(2'd0, mk(8'hFF, 8'hFF, 1, 1, 0, 0, 0, 1, 0));
    rnd_evt(5);

    cur_req = "R2";
    wr(2'd0, mk(1, 8'h24, 1, 1, 0, 0, 0, 1, 0));
    rnd_evt(8);
    for (int m = 0; m < 8; m++) begin
      wr(2'd0, mk(2, 1 << m, 1, 1, 0, 0, 0, 1, 0));
      rnd_evt(3);
    end

    cur_req = "R3";
    wr(2'd0, mk(3, 8'hFF, 1, 1, 1, 0, 1, 1, 0));
    rnd_evt(10);

    cur_req = "R4";
    for (int th = 1; th <= 25; th += 3) begin
      wr(2'd0, mk(0, 8'hFF, 1, 1, 0, 0, 0, 1, th));
      rnd_evt(8);
    end

    cur_req = "R5";
    wr(2'd0, mk(0, 8'h0F, 1, 1, 0, 0, 1, 1, 1));
    rnd_evt(12);
    wr(2'd0, mk(0, 8'hFF, 1, 1, 0, 0, 1, 1, 12));
    rnd_evt(12);

    cur_req = "R6";
    wr(2'd0, mk(0, 8'h01, 1, 1, 1, 0, 0, 1, 1));
    for (int r = 0; r < 6; r++) begin
      evt = '0; evt[0 +: SUB_W] = 1; step(); step(); step();
      evt = '0; step(); step();
    end
    evt = '0; evt[0 +: SUB_W] = 2;
    step(); step();
    wr(2'd0, mk(0, 8'h01, 1, 1, 1, 0, 0, 0, 1));
    step();
    wr(2'd0, mk(0, 8'h01, 1, 1, 1, 0, 0, 1, 1));
    step(); step(); step();
    wr(2'd0, mk(0, 8'hFF, 1, 1, 1, 0, 1, 1, 6));
    rnd_evt(20);

    cur_req = "R7";
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        wr(2'd0, mk(1, 8'hFF, k[0], k[1], 0, 0, 0, 1, 0));
        priv = 2'(p);
        rnd_evt(4);
      end
    end
    priv = 2'd0;

    cur_req = "R9";
    wr(2'd0, mk(0, 8'hFF, 1, 1, 0, 0, 0, 1, 0));
    evt = '1;
    wr(2'd1, 64'h0000_1234_5678_9ABC);
    step();
    wr(2'd1, 64'h0);
    rnd_evt(4);

    cur_req = "R10";
    wr(2'd0, mk(0, 8'hFF, 1, 1, 0, 1, 0, 1, 0));
    wr(2'd1, 64'h0000_FFFF_FFFF_FFF0);
    evt = '1;
    step(); step();
    rd(2'd2);
    evt = '0;
    rd(2'd2);
    wr(2'd2, 64'h0);
    rd(2'd2);
    wr(2'd2, 64'h1);
    rd(2'd2);
    wr(2'd1, 64'h0000_FFFF_FFFF_FFFE);
    evt = '1;
    addr = 2'd2; we = 1'b1; wdata = 64'h1;
    step();
    we = 1'b0;
    step();
    addr = 2'd1;
    wr(2'd0, mk(0, 8'hFF, 1, 1, 0, 0, 0, 1, 0));
    rd(2'd2);
    wr(2'd2, 64'h1);
    rd(2'd2);

    cur_req = "R4";
    for (int i = 0; i < 40; i++) begin
      wr(2'd0, mk($urandom_range(0, NUM_EVT), $urandom, 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 20)));
      priv = 2'($urandom);
      rnd_evt(6);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule